// File: doc/BRIEF.md
# Router IO Control Register Block

This block is a small memory-mapped control and status unit on a CPU register bus. Software reaches it through single-cycle read and write strobes carrying an 18-bit offset and 16-bit data. It returns fixed identification words: chassis model, boot flash size, flash write enable and environmental health. It also builds an active-low module presence word from per-slot detect inputs.

Two serial EEPROM ports are bit-banged through register bits. The mainboard port drives its pins straight from a register. The module port carries a slot number in its low bits and routes its pin bits to the chosen slot only. Each of three interrupt lines is raised by a source pulse and is acknowledged by touching its status offset. The network line is deferred: it drops only on the sixteenth access to its status window. A byte-wide mask register gives software general storage. Any access to an undecoded offset sets a sticky flag.

Top module: `rio_ctl_regs`

## Requirements
- R1: After reset all three interrupt outputs are low, all EEPROM pin outputs are low, the unknown-access flag is low, and the EEPROM and mask registers read back zero.
- R2: Reads return 0x00FF at offset 0x00008, 0x1000 at 0x0000A and 0x0021 at 0x30004. Offset 0x30000 returns the chassis code in bits 7:5: code 4 for the two-slot model (the default, reading 0x0080), 0 for four slots and 3 for six slots.
- R3: Offset 0x10006 reads a presence word that starts from 0xFFFF. For every slot i (0..3) whose detect input is high, bits i, i+4, i+8 and i+12 are cleared.
- R4: A write to 0x0000E stores all 16 bits. The mainboard pins follow the stored value: bit 0 is chip select, bit 1 is clock and bit 2 is data-in. A read returns the stored value with bit 3 replaced by the live data-out input.
- R5: A write to 0x10008 stores all 16 bits, and bits 1:0 select the slot. Only the selected slot's pins are driven: bit 4 is chip select, bit 2 is clock and bit 6 is data-in. All other slots' pins stay low. A read returns the stored value with bit 7 replaced by the selected slot's data-out input.
- R6: Each read or write to offsets 0x20000 to 0x20003 advances a counter. The access that brings it to 16 clears the network interrupt and restarts the count. Earlier accesses leave the interrupt set. Reads of these offsets return 0x00FF.
- R7: Any access to 0x20004 clears the module-management interrupt, and any access to 0x20006 clears the external interrupt. Both offsets read zero.
- R8: A set pulse raises its interrupt on the next clock edge. A set in the same cycle as an acknowledge wins, and the interrupt stays high.
- R9: Offset 0x20008 holds the low 8 bits of the last write and reads them back zero-extended. Writes to 0x0000C are accepted but change no register, pin or flag.
- R10: Reads of undecoded offsets return zero and writes to them change no register. Any access to an undecoded offset sets a sticky unknown-access flag, and the flag stays set until reset.
- R11: Read data is combinational in the cycle of the read strobe and is zero whenever no read strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 18 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rd is high |
| slot_present | input | 4 | Per-slot module detect, high = fitted |
| mb_ee_cs | output | 1 | Mainboard EEPROM chip select |
| mb_ee_clk | output | 1 | Mainboard EEPROM clock |
| mb_ee_di | output | 1 | Mainboard EEPROM data toward the device |
| mb_ee_do | input | 1 | Mainboard EEPROM data from the device |
| mod_ee_cs | output | 4 | Per-slot module EEPROM chip select |
| mod_ee_clk | output | 4 | Per-slot module EEPROM clock |
| mod_ee_di | output | 4 | Per-slot module EEPROM data toward the device |
| mod_ee_do | input | 4 | Per-slot module EEPROM data from the device |
| net_irq_set | input | 1 | Network interrupt source pulse |
| mgmt_irq_set | input | 1 | Module-management interrupt source pulse |
| ext_irq_set | input | 1 | External interrupt source pulse |
| net_irq | output | 1 | Network interrupt |
| mgmt_irq | output | 1 | Module-management interrupt |
| ext_irq | output | 1 | External interrupt |
| unknown_seen | output | 1 | Sticky flag for undecoded accesses |

## Verification
The presence word is read under detect patterns of no slots, a single slot, alternating slots, all slots and a lone middle slot. These show whether each slot's clear mask lands on the right four bits and whether masks combine correctly. The network deferral is exercised with reads spread over all four status offsets plus a write. This tells whether every offset and both strobe types advance the count, and whether the clear lands on the sixteenth access and not on the fifteenth. Module EEPROM traffic is sent to every slot with data-out patterns both matching and opposing the selection, which tells true routing apart from a fixed slot.

// File: rtl/rio_pkg.sv
package rio_pkg;

  localparam int RIO_AW = 18;
  localparam int RIO_DW = 16;

  localparam logic [RIO_AW-1:0] OFF_FLASH_WP = 18'h00008;
  localparam logic [RIO_AW-1:0] OFF_BOOT_SZ  = 18'h0000A;
  localparam logic [RIO_AW-1:0] OFF_WDOG     = 18'h0000C;
  localparam logic [RIO_AW-1:0] OFF_MB_EE    = 18'h0000E;
  localparam logic [RIO_AW-1:0] OFF_PRESENCE = 18'h10006;
  localparam logic [RIO_AW-1:0] OFF_MOD_EE   = 18'h10008;
  localparam logic [RIO_AW-1:0] OFF_NET_BASE = 18'h20000;
  localparam logic [RIO_AW-1:0] OFF_MGMT     = 18'h20004;
  localparam logic [RIO_AW-1:0] OFF_EXT      = 18'h20006;
  localparam logic [RIO_AW-1:0] OFF_MASK     = 18'h20008;
  localparam logic [RIO_AW-1:0] OFF_CHASSIS  = 18'h30000;
  localparam logic [RIO_AW-1:0] OFF_ENV      = 18'h30004;

  localparam logic [RIO_DW-1:0] VAL_FLASH_WP = 16'h00FF;
  localparam logic [RIO_DW-1:0] VAL_BOOT_SZ  = 16'h1000;
  localparam logic [RIO_DW-1:0] VAL_ENV      = 16'h0021;
  localparam logic [RIO_DW-1:0] VAL_NET_STAT = 16'h00FF;

  // Pin bit positions inside the two EEPROM registers
  localparam int MB_CS  = 0;
  localparam int MB_CLK = 1;
  localparam int MB_DI  = 2;
  localparam int MB_DO  = 3;
  localparam int MOD_CS  = 4;
  localparam int MOD_CLK = 2;
  localparam int MOD_DI  = 6;
  localparam int MOD_DO  = 7;

  typedef struct packed {
    logic flash_wp;
    logic boot_sz;
    logic wdog;
    logic mb_ee;
    logic presence;
    logic mod_ee;
    logic net;
    logic mgmt;
    logic ext;
    logic mask;
    logic chassis;
    logic env;
  } rio_hit_t;

  function automatic logic [2:0] chassis_code(input int model_slots);
    case (model_slots)
      2:       chassis_code = 3'd4;
      4:       chassis_code = 3'd0;
      6:       chassis_code = 3'd3;
      default: chassis_code = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/rio_decode.sv
module rio_decode
  import rio_pkg::*;
(
  input  logic [RIO_AW-1:0] addr,
  output rio_hit_t          hit
);

  always_comb begin
    hit     = '0;
    hit.net = (addr[RIO_AW-1:2] == OFF_NET_BASE[RIO_AW-1:2]);
    case (addr)
      OFF_FLASH_WP: hit.flash_wp = 1'b1;
      OFF_BOOT_SZ:  hit.boot_sz  = 1'b1;
      OFF_WDOG:     hit.wdog     = 1'b1;
      OFF_MB_EE:    hit.mb_ee    = 1'b1;
      OFF_PRESENCE: hit.presence = 1'b1;
      OFF_MOD_EE:   hit.mod_ee   = 1'b1;
      OFF_MGMT:     hit.mgmt     = 1'b1;
      OFF_EXT:      hit.ext      = 1'b1;
      OFF_MASK:     hit.mask     = 1'b1;
      OFF_CHASSIS:  hit.chassis  = 1'b1;
      OFF_ENV:      hit.env      = 1'b1;
      default:      ;
    endcase
  end

endmodule

// File: rtl/rio_ee_ports.sv
module rio_ee_ports
  import rio_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mb_we,
  input  logic                 mod_we,
  input  logic [RIO_DW-1:0]    wdata,
  input  logic                 mb_do,
  input  logic [NUM_SLOTS-1:0] mod_do,
  output logic                 mb_cs,
  output logic                 mb_clk,
  output logic                 mb_di,
  output logic [NUM_SLOTS-1:0] mod_cs,
  output logic [NUM_SLOTS-1:0] mod_clk,
  output logic [NUM_SLOTS-1:0] mod_di,
  output logic [RIO_DW-1:0]    mb_rd,
  output logic [RIO_DW-1:0]    mod_rd
);

  logic [RIO_DW-1:0] mb_q, mb_d;
  logic [RIO_DW-1:0] mod_q, mod_d;
  logic [SLOT_W-1:0] sel;

  always_comb begin
    mb_d  = mb_we  ? wdata : mb_q;
    mod_d = mod_we ? wdata : mod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb_q  <= '0;
      mod_q <= '0;
    end else begin
      if (mb_we)  mb_q  <= mb_d;
      if (mod_we) mod_q <= mod_d;
    end
  end

  assign sel    = mod_q[SLOT_W-1:0];
  assign mb_cs  = mb_q[MB_CS];
  assign mb_clk = mb_q[MB_CLK];
  assign mb_di  = mb_q[MB_DI];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic chosen;
    assign chosen     = (sel == SLOT_W'(s));
    assign mod_cs[s]  = chosen & mod_q[MOD_CS];
    assign mod_clk[s] = chosen & mod_q[MOD_CLK];
    assign mod_di[s]  = chosen & mod_q[MOD_DI];
  end

  always_comb begin
    mb_rd         = mb_q;
    mb_rd[MB_DO]  = mb_do;
    mod_rd        = mod_q;
    mod_rd[MOD_DO] = mod_do[sel];
  end

endmodule

// File: rtl/rio_irq_ctl.sv
module rio_irq_ctl #(
  parameter int CLR_COUNT = 16,
  localparam int CNT_W = $clog2(CLR_COUNT + 1)
)(
  input  logic clk,
  input  logic rst_n,
  input  logic net_set,
  input  logic mgmt_set,
  input  logic ext_set,
  input  logic net_acc,
  input  logic mgmt_acc,
  input  logic ext_acc,
  output logic net_irq,
  output logic mgmt_irq,
  output logic ext_irq
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;
  logic             net_q, net_d;
  logic             mgmt_q, mgmt_d;
  logic             ext_q, ext_d;

  always_comb begin
    wrap  = 1'b0;
    cnt_d = cnt_q;
    if (net_acc) begin
      if (cnt_q == CNT_W'(CLR_COUNT - 1)) begin
        wrap  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    net_d  = net_set  | (net_q  & ~wrap);
    mgmt_d = mgmt_set | (mgmt_q & ~mgmt_acc);
    ext_d  = ext_set  | (ext_q  & ~ext_acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      net_q  <= 1'b0;
      mgmt_q <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      if (net_acc) cnt_q <= cnt_d;
      net_q  <= net_d;
      mgmt_q <= mgmt_d;
      ext_q  <= ext_d;
    end
  end

  assign net_irq  = net_q;
  assign mgmt_irq = mgmt_q;
  assign ext_irq  = ext_q;

endmodule

// File: rtl/rio_ctl_regs.sv
module rio_ctl_regs
  import rio_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int CLR_COUNT   = 16,
  parameter int MODEL_SLOTS = 2,
  parameter int MASK_W      = 8
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [RIO_AW-1:0]    bus_addr,
  input  logic [RIO_DW-1:0]    bus_wdata,
  output logic [RIO_DW-1:0]    bus_rdata,
  input  logic [NUM_SLOTS-1:0] slot_present,
  output logic                 mb_ee_cs,
  output logic                 mb_ee_clk,
  output logic                 mb_ee_di,
  input  logic                 mb_ee_do,
  output logic [NUM_SLOTS-1:0] mod_ee_cs,
  output logic [NUM_SLOTS-1:0] mod_ee_clk,
  output logic [NUM_SLOTS-1:0] mod_ee_di,
  input  logic [NUM_SLOTS-1:0] mod_ee_do,
  input  logic                 net_irq_set,
  input  logic                 mgmt_irq_set,
  input  logic                 ext_irq_set,
  output logic                 net_irq,
  output logic                 mgmt_irq,
  output logic                 ext_irq,
  output logic                 unknown_seen
);

  localparam logic [2:0] CHASSIS = chassis_code(MODEL_SLOTS);

  rio_hit_t          hit;
  logic              acc, known;
  logic [RIO_DW-1:0] mb_rd, mod_rd, pres_word;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              mask_en;
  logic              unk_q, unk_d;

  assign acc   = bus_rd | bus_wr;
  assign known = |hit;

  rio_decode u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  rio_ee_ports #(.NUM_SLOTS(NUM_SLOTS)) u_ee (
    .clk     (clk),
    .rst_n   (rst_n),
    .mb_we   (bus_wr & hit.mb_ee),
    .mod_we  (bus_wr & hit.mod_ee),
    .wdata   (bus_wdata),
    .mb_do   (mb_ee_do),
    .mod_do  (mod_ee_do),
    .mb_cs   (mb_ee_cs),
    .mb_clk  (mb_ee_clk),
    .mb_di   (mb_ee_di),
    .mod_cs  (mod_ee_cs),
    .mod_clk (mod_ee_clk),
    .mod_di  (mod_ee_di),
    .mb_rd   (mb_rd),
    .mod_rd  (mod_rd)
  );

  rio_irq_ctl #(.CLR_COUNT(CLR_COUNT)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .net_set  (net_irq_set),
    .mgmt_set (mgmt_irq_set),
    .ext_set  (ext_irq_set),
    .net_acc  (acc & hit.net),
    .mgmt_acc (acc & hit.mgmt),
    .ext_acc  (acc & hit.ext),
    .net_irq  (net_irq),
    .mgmt_irq (mgmt_irq),
    .ext_irq  (ext_irq)
  );

  // Active-low presence, each slot owning one bit per nibble
  always_comb begin
    pres_word = '1;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slot_present[i]) pres_word &= ~(RIO_DW'(16'h1111) << i);
    end
  end

  always_comb begin
    mask_en = bus_wr & hit.mask;
    mask_d  = mask_en ? bus_wdata[MASK_W-1:0] : mask_q;
    unk_d   = unk_q | (acc & ~known);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      unk_q  <= 1'b0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      unk_q <= unk_d;
    end
  end

  assign unknown_seen = unk_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit.flash_wp)      bus_rdata = VAL_FLASH_WP;
      else if (hit.boot_sz)  bus_rdata = VAL_BOOT_SZ;
      else if (hit.mb_ee)    bus_rdata = mb_rd;
      else if (hit.presence) bus_rdata = pres_word;
      else if (hit.mod_ee)   bus_rdata = mod_rd;
      else if (hit.net)      bus_rdata = VAL_NET_STAT;
      else if (hit.mask)     bus_rdata = RIO_DW'(mask_q);
      else if (hit.chassis)  bus_rdata = RIO_DW'({CHASSIS, 5'b0});
      else if (hit.env)      bus_rdata = VAL_ENV;
      else                   bus_rdata = '0;
    end
  end

endmodule

// File: rtl/rio_ctl_regs_chk.sv
module rio_ctl_regs_chk
  import rio_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CLR_COUNT = 16,
  localparam int CNT_W = $clog2(CLR_COUNT + 1)
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_rd,
  input logic                 bus_wr,
  input logic [RIO_AW-1:0]    bus_addr,
  input logic [RIO_DW-1:0]    bus_rdata,
  input logic [NUM_SLOTS-1:0] mod_ee_cs,
  input logic                 net_irq_set,
  input logic                 mgmt_irq_set,
  input logic                 ext_irq_set,
  input logic                 net_irq,
  input logic                 mgmt_irq,
  input logic                 ext_irq,
  input logic                 unknown_seen
);

  logic             acc, net_acc, mgmt_acc, ext_acc, last_acc;
  logic [CNT_W-1:0] seen_q;

  assign acc      = bus_rd | bus_wr;
  assign net_acc  = acc && (bus_addr >= OFF_NET_BASE) && (bus_addr <= OFF_NET_BASE + 18'd3);
  assign mgmt_acc = acc && (bus_addr == OFF_MGMT);
  assign ext_acc  = acc && (bus_addr == OFF_EXT);
  assign last_acc = net_acc && (seen_q == CNT_W'(CLR_COUNT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= '0;
    else if (net_acc) seen_q <= last_acc ? '0 : seen_q + 1'b1;
  end

  a_r6_clear_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last_acc && !net_irq_set) |=> !net_irq);
  a_r6_hold_before_last: assert property (@(posedge clk) disable iff (!rst_n)
    (net_irq && !last_acc) |=> net_irq);
  a_r7_mgmt_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_acc && !mgmt_irq_set) |=> !mgmt_irq);
  a_r7_ext_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_acc && !ext_irq_set) |=> !ext_irq);
  a_r8_net_set: assert property (@(posedge clk) disable iff (!rst_n)
    net_irq_set |=> net_irq);
  a_r8_mgmt_set: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_irq_set |=> mgmt_irq);
  a_r8_ext_set: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq_set |=> ext_irq);
  a_r5_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mod_ee_cs));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unknown_seen |=> unknown_seen);
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));

endmodule

bind rio_ctl_regs rio_ctl_regs_chk #(.NUM_SLOTS(NUM_SLOTS), .CLR_COUNT(CLR_COUNT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_rd       (bus_rd),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_rdata    (bus_rdata),
  .mod_ee_cs    (mod_ee_cs),
  .net_irq_set  (net_irq_set),
  .mgmt_irq_set (mgmt_irq_set),
  .ext_irq_set  (ext_irq_set),
  .net_irq      (net_irq),
  .mgmt_irq     (mgmt_irq),
  .ext_irq      (ext_irq),
  .unknown_seen (unknown_seen)
);

// File: tb/rio_ctl_regs_bench.sv
module rio_ctl_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [17:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  slot_present = '0;
  logic        mb_ee_cs, mb_ee_clk, mb_ee_di;
  logic        mb_ee_do = 1'b0;
  logic [3:0]  mod_ee_cs, mod_ee_clk, mod_ee_di;
  logic [3:0]  mod_ee_do = '0;
  logic        net_irq_set = 1'b0, mgmt_irq_set = 1'b0, ext_irq_set = 1'b0;
  logic        net_irq, mgmt_irq, ext_irq, unknown_seen;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rio_ctl_regs u_rio_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .slot_present(slot_present),
    .mb_ee_cs(mb_ee_cs), .mb_ee_clk(mb_ee_clk), .mb_ee_di(mb_ee_di), .mb_ee_do(mb_ee_do),
    .mod_ee_cs(mod_ee_cs), .mod_ee_clk(mod_ee_clk), .mod_ee_di(mod_ee_di), .mod_ee_do(mod_ee_do),
    .net_irq_set(net_irq_set), .mgmt_irq_set(mgmt_irq_set), .ext_irq_set(ext_irq_set),
    .net_irq(net_irq), .mgmt_irq(mgmt_irq), .ext_irq(ext_irq), .unknown_seen(unknown_seen)
  );

  // Behavioural reference state
  bit       m_net, m_mgmt, m_ext, m_unk;
  int       m_cnt;
  bit [15:0] m_mb, m_mod;
  bit [7:0]  m_mask;

  function automatic bit known_off(input logic [17:0] a);
    return a inside {18'h00008, 18'h0000A, 18'h0000C, 18'h0000E, 18'h10006, 18'h10008,
                     18'h20000, 18'h20001, 18'h20002, 18'h20003, 18'h20004, 18'h20006,
                     18'h20008, 18'h30000, 18'h30004};
  endfunction

  function automatic logic [15:0] exp_read(input logic [17:0] a);
    logic [15:0] v;
    case (a)
      18'h00008: v = 16'h00FF;
      18'h0000A: v = 16'h1000;
      18'h0000E: begin v = m_mb; v[3] = mb_ee_do; end
      18'h10006: begin
        v = 16'hFFFF;
        for (int i = 0; i < 4; i++)
          if (slot_present[i]) begin
            v[i] = 1'b0; v[i+4] = 1'b0; v[i+8] = 1'b0; v[i+12] = 1'b0;
          end
      end
      18'h10008: begin v = m_mod; v[7] = mod_ee_do[m_mod[1:0]]; end
      18'h20000, 18'h20001, 18'h20002, 18'h20003: v = 16'h00FF;
      18'h20008: v = {8'h00, m_mask};
      18'h30000: v = 16'h0080;
      18'h30004: v = 16'h0021;
      default:   v = 16'h0000;
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_net <= 0; m_mgmt <= 0; m_ext <= 0; m_unk <= 0; m_cnt <= 0;
      m_mb <= '0; m_mod <= '0; m_mask <= '0;
    end else begin
      automatic bit acc = bus_rd | bus_wr;
      automatic bit drop = 0;
      if (acc && bus_addr >= 18'h20000 && bus_addr <= 18'h20003) begin
        if (m_cnt + 1 == 16) begin m_cnt <= 0; drop = 1; end
        else m_cnt <= m_cnt + 1;
      end
      m_net  <= net_irq_set  ? 1'b1 : (drop ? 1'b0 : m_net);
      m_mgmt <= mgmt_irq_set ? 1'b1 : ((acc && bus_addr == 18'h20004) ? 1'b0 : m_mgmt);
      m_ext  <= ext_irq_set  ? 1'b1 : ((acc && bus_addr == 18'h20006) ? 1'b0 : m_ext);
      if (acc && !known_off(bus_addr)) m_unk <= 1'b1;
      if (bus_wr) begin
        if (bus_addr == 18'h0000E) m_mb <= bus_wdata;
        if (bus_addr == 18'h10008) m_mod <= bus_wdata;
        if (bus_addr == 18'h20008) m_mask <= bus_wdata[7:0];
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference, after both have updated
  always begin
    @(posedge clk);
    #1;
    if (rst_n && !finished) begin
      check("R6 net_irq", {15'd0, net_irq}, {15'd0, m_net});
      check("R7 R8 mgmt_irq", {15'd0, mgmt_irq}, {15'd0, m_mgmt});
      check("R7 R8 ext_irq", {15'd0, ext_irq}, {15'd0, m_ext});
      check("R10 unknown_seen", {15'd0, unknown_seen}, {15'd0, m_unk});
      check("R4 mb pins", {13'd0, mb_ee_di, mb_ee_clk, mb_ee_cs}, {13'd0, m_mb[2], m_mb[1], m_mb[0]});
      for (int s = 0; s < 4; s++) begin
        automatic bit ch = (m_mod[1:0] == s);
        check("R5 mod pins", {13'd0, mod_ee_di[s], mod_ee_clk[s], mod_ee_cs[s]},
              {13'd0, ch & m_mod[6], ch & m_mod[2], ch & m_mod[4]});
      end
      if (!bus_rd) check("R11 idle rdata", bus_rdata, 16'h0000);
    end
  end

  task automatic rd(input string req, input logic [17:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 check(req, bus_rdata, exp_read(a));
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [17:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse_net();
    @(negedge clk); net_irq_set = 1'b1;
    @(negedge clk); net_irq_set = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irqs", {13'd0, net_irq, mgmt_irq, ext_irq}, 16'h0000);
    check("R1 pins", {3'd0, mb_ee_cs, mb_ee_clk, mb_ee_di, mod_ee_cs, mod_ee_clk, mod_ee_di}, 16'h0000);
    check("R1 unknown", {15'd0, unknown_seen}, 16'h0000);
    rst_n = 1'b1;
    rd("R1 mb reg", 18'h0000E);
    rd("R1 mod reg", 18'h10008);
    rd("R1 mask reg", 18'h20008);

    // R2 fixed words
    rd("R2 flash", 18'h00008);
    rd("R2 boot", 18'h0000A);
    rd("R2 env", 18'h30004);
    rd("R2 chassis", 18'h30000);
    check("R2 chassis literal", exp_read(18'h30000), 16'h0080);

    // R3 presence patterns
    foreach (slot_present[i]) ;
    for (int p = 0; p < 5; p++) begin
      slot_present = (p == 0) ? 4'b0000 : (p == 1) ? 4'b0001 : (p == 2) ? 4'b1010 :
                     (p == 3) ? 4'b1111 : 4'b0100;
      rd("R3 presence", 18'h10006);
    end
    slot_present = 4'b1010;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 18'h10006;
    #1 check("R3 presence literal", bus_rdata, 16'h5555);
    @(negedge clk); bus_rd = 1'b0;

    // R4 mainboard port
    wr(18'h0000E, 16'hA5F7);
    mb_ee_do = 1'b0; rd("R4 mb do=0", 18'h0000E);
    mb_ee_do = 1'b1; rd("R4 mb do=1", 18'h0000E);
    wr(18'h0000E, 16'h0008);
    mb_ee_do = 1'b0; rd("R4 mb cleared", 18'h0000E);

    // R5 module port, every slot
    for (int s = 0; s < 4; s++) begin
      wr(18'h10008, 16'h3054 | 16'(s));
      mod_ee_do = 4'(1 << s);  rd("R5 mod do sel", 18'h10008);
      mod_ee_do = ~4'(1 << s); rd("R5 mod do other", 18'h10008);
    end
    wr(18'h10008, 16'h0002);

    // R6 deferred network clear
    pulse_net();
    for (int k = 0; k < 15; k++) begin
      if (k == 7) wr(18'h20001, 16'h1234);
      else rd("R6 net status", 18'h20000 + 18'(k % 4));
    end
    check("R6 still set after 15", {15'd0, net_irq}, 16'h0001);
    rd("R6 sixteenth", 18'h20003);
    check("R6 cleared on 16", {15'd0, net_irq}, 16'h0000);

    // R7 acknowledges
    @(negedge clk); mgmt_irq_set = 1'b1; ext_irq_set = 1'b1;
    @(negedge clk); mgmt_irq_set = 1'b0; ext_irq_set = 1'b0;
    rd("R7 mgmt read", 18'h20004);
    check("R7 mgmt cleared", {15'd0, mgmt_irq}, 16'h0000);
    check("R7 ext still set", {15'd0, ext_irq}, 16'h0001);
    wr(18'h20006, 16'hFFFF);
    check("R7 ext cleared", {15'd0, ext_irq}, 16'h0000);

    // R8 set wins over acknowledge
    @(negedge clk);
    mgmt_irq_set = 1'b1; bus_rd = 1'b1; bus_addr = 18'h20004;
    #1 check("R8 mgmt read", bus_rdata, 16'h0000);
    @(negedge clk); mgmt_irq_set = 1'b0; bus_rd = 1'b0;
    check("R8 set wins", {15'd0, mgmt_irq}, 16'h0001);

    // R9 mask and ignored offset
    wr(18'h20008, 16'h12A5);
    rd("R9 mask", 18'h20008);
    wr(18'h0000C, 16'h7D00);
    rd("R9 mask after ignored", 18'h20008);
    check("R9 no unknown", {15'd0, unknown_seen}, 16'h0000);

    // R10 undecoded
    rd("R10 undecoded read", 18'h10004);
    check("R10 flag set", {15'd0, unknown_seen}, 16'h0001);
    wr(18'h30002, 16'hFFFF);
    rd("R10 mask untouched", 18'h20008);
    rd("R10 mb untouched", 18'h0000E);
    repeat (3) @(negedge clk);
    check("R10 flag sticky", {15'd0, unknown_seen}, 16'h0001);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule